// File: doc/BRIEF.md
# Two-Level Nested Interrupt Arbiter

This block sits beside a processor core and decides, at each instruction boundary, whether a pending interrupt is taken. It serves one non-maskable source and `N_SRC` maskable sources. Each maskable source has a one-bit priority flag: 0 means high and 1 means low. A global enable flag gates the maskable sources. An in-service flag records the level now being served. It reads 0 while a high-priority handler runs, and 1 when idle or while a low-priority handler runs.

On every acknowledge the block saves the enable flag, the in-service flag and the non-maskable busy state on an internal stack that is `N_SRC+1` frames deep. It then clears the enable flag and loads the in-service flag from the priority of the source it accepted. A return strobe restores the saved frame. After a return, the block lets exactly one main-program instruction finish before it grants anything. Requests that are refused stay latched until they are served. The core fetches the handler itself, using the registered index that the block returns.

Top module: `nest_irq_arbiter`

## Requirements
- R1: After a synchronous reset the enable flag is 0, the in-service flag is 1, the non-maskable busy flag is 0, the acknowledge is 0 and the stack is empty.
- R2: A maskable request is granted only while the enable flag is 1. An enable-set strobe makes the flag 1 and an enable-clear strobe makes it 0; clear wins when both arrive together. Both strobes are ignored in a cycle with a grant or a return.
- R3: The acknowledge is a registered one-clock output that rises in the cycle after a boundary strobe that caused a grant. The same edge loads the index of the accepted source and clears the enable flag.
- R4: Any eligible high-priority request (priority flag 0) wins over every low-priority one (flag 1). Among requests of the same level, the lowest-numbered source wins.
- R5: On a maskable grant the in-service flag takes the priority flag of the accepted source. While the in-service flag is 0, low-priority requests are refused. A high-priority request may still nest, and any request may nest while the flag is 1.
- R6: A request refused because of the enable flag, its level or a hold-off stays pending and is granted later, once it becomes eligible.
- R7: A return strobe restores the enable, in-service and non-maskable busy flags that were saved by the most recent unreturned grant.
- R8: A grant never happens in the cycle of a return strobe, nor at the first boundary strobe after it. The second boundary strobe after a return may grant.
- R9: A pending non-maskable request is granted at a boundary whatever the enable flag holds, and it beats all maskable requests. Its index is `N_SRC`, and it sets the busy flag and clears the in-service flag. While the busy flag is 1, nothing is granted.
- R10: A source's pending bit is cleared by its own grant, so a single request pulse gives exactly one acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_SRC | Maskable request pulses, latched until granted |
| nmi_i | input | 1 | Non-maskable request pulse, latched until granted |
| prio_i | input | N_SRC | Priority flag per source, 0 high, 1 low |
| boundary_i | input | 1 | Instruction-boundary strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| ei_i | input | 1 | Enable-set strobe |
| di_i | input | 1 | Enable-clear strobe |
| ack_o | output | 1 | One-clock acknowledge pulse |
| vec_o | output | $clog2(N_SRC+1) | Index of the accepted source, N_SRC for non-maskable |
| ie_o | output | 1 | Current global enable flag |
| isp_o | output | 1 | Current in-service flag |
| nmi_busy_o | output | 1 | Non-maskable handler in service |

## Verification
The assertions take `prio_i` to be stable from the boundary strobe that causes a grant until the edge after it. The priority check on a granted source compares against the value registered one cycle earlier. The bench changes priority flags only in cycles that carry no boundary strobe. It issues return strobes only while its own model holds a saved frame, so every pop restores a real frame. The hold-off rule is checked with returns that arrive both on and off boundary strobes, and the nesting limit of the stack is left to the grant gating.

// File: rtl/nia_pkg.sv
package nia_pkg;
  // Frame saved on the flag stack at every acknowledge
  typedef struct packed {
    logic nmi_busy;
    logic ie;
    logic isp;
  } nia_frame_t;
endpackage

// File: rtl/nia_pending.sv
module nia_pending #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  input  logic             nmi_i,
  input  logic [N_SRC-1:0] clr_mask_i,
  input  logic             clr_nmi_i,
  output logic [N_SRC-1:0] pend_o,
  output logic             nmi_pend_o
);
  logic [N_SRC-1:0] pend_q;
  logic             nmi_q;

  // A new pulse in the same cycle as a grant of that source is kept
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      nmi_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~clr_mask_i) | req_i;
      nmi_q  <= (nmi_q & ~clr_nmi_i) | nmi_i;
    end
  end

  assign pend_o     = pend_q;
  assign nmi_pend_o = nmi_q;
endmodule

// File: rtl/nia_select.sv
module nia_select #(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0] pend_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             nmi_pend_i,
  input  logic             allow_i,
  input  logic             ie_i,
  input  logic             isp_i,
  input  logic             nmi_busy_i,
  output logic             grant_o,
  output logic             grant_nmi_o,
  output logic [IDX_W-1:0] grant_idx_o,
  output logic             grant_prio_o,
  output logic [N_SRC-1:0] grant_mask_o
);
  localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(N_SRC);

  logic             hi_found, lo_found;
  logic [IDX_W-1:0] hi_idx, lo_idx;

  // Scan downward so the lowest-numbered candidate is the last one kept
  always_comb begin
    hi_found = 1'b0;
    lo_found = 1'b0;
    hi_idx   = '0;
    lo_idx   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && !prio_i[i]) begin
        hi_found = 1'b1;
        hi_idx   = IDX_W'(i);
      end
      if (pend_i[i] && prio_i[i]) begin
        lo_found = 1'b1;
        lo_idx   = IDX_W'(i);
      end
    end
  end

  logic take_nmi, take_hi, take_lo;
  assign take_nmi = allow_i && nmi_pend_i && !nmi_busy_i;
  assign take_hi  = allow_i && !take_nmi && !nmi_busy_i && ie_i && hi_found;
  assign take_lo  = allow_i && !take_nmi && !nmi_busy_i && ie_i && !hi_found
                    && lo_found && isp_i;

  assign grant_o      = take_nmi || take_hi || take_lo;
  assign grant_nmi_o  = take_nmi;
  assign grant_prio_o = take_lo;
  assign grant_idx_o  = take_nmi ? NMI_IDX : (take_hi ? hi_idx : lo_idx);

  for (genvar g = 0; g < N_SRC; g++) begin : g_clr
    assign grant_mask_o[g] = (take_hi || take_lo) && (grant_idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/nia_flag_stack.sv
module nia_flag_stack
  import nia_pkg::*;
#(
  parameter int DEPTH = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push_i,
  input  logic       pop_i,
  input  nia_frame_t din_i,
  output nia_frame_t dout_o,
  output logic       full_o,
  output logic       empty_o
);
  nia_frame_t    mem [DEPTH];
  logic [PW-1:0] sp_q;

  // Storage has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (push_i && !full_o) mem[AW'(sp_q)] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= '0;
    end else if (push_i && !full_o) begin
      sp_q <= sp_q + PW'(1);
    end else if (pop_i && !empty_o) begin
      sp_q <= sp_q - PW'(1);
    end
  end

  assign dout_o  = mem[AW'(sp_q - PW'(1))];
  assign full_o  = (sp_q == PW'(DEPTH));
  assign empty_o = (sp_q == '0);
endmodule

// File: rtl/nest_irq_arbiter.sv
module nest_irq_arbiter
  import nia_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC + 1),
  localparam int DEPTH = N_SRC + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  input  logic             nmi_i,
  input  logic [N_SRC-1:0] prio_i,
  input  logic             boundary_i,
  input  logic             reti_i,
  input  logic             ei_i,
  input  logic             di_i,
  output logic             ack_o,
  output logic [IDX_W-1:0] vec_o,
  output logic             ie_o,
  output logic             isp_o,
  output logic             nmi_busy_o
);
  logic [N_SRC-1:0] pend, clr_mask;
  logic             nmi_pend;
  logic             grant, grant_nmi, grant_prio;
  logic [IDX_W-1:0] grant_idx;
  logic             allow, skip_q, full, empty;
  logic             ie_q, isp_q, nmi_busy_q, ack_q;
  logic [IDX_W-1:0] vec_q;
  nia_frame_t       top_frame, save_frame;

  nia_pending #(.N_SRC(N_SRC)) u_pend (
    .clk(clk), .rst(rst), .req_i(req_i), .nmi_i(nmi_i),
    .clr_mask_i(clr_mask), .clr_nmi_i(grant_nmi),
    .pend_o(pend), .nmi_pend_o(nmi_pend)
  );

  // Grants wait for a boundary, no return this cycle, no hold-off, and room on the stack
  assign allow = boundary_i && !reti_i && !skip_q && !full;

  nia_select #(.N_SRC(N_SRC)) u_sel (
    .pend_i(pend), .prio_i(prio_i), .nmi_pend_i(nmi_pend), .allow_i(allow),
    .ie_i(ie_q), .isp_i(isp_q), .nmi_busy_i(nmi_busy_q),
    .grant_o(grant), .grant_nmi_o(grant_nmi), .grant_idx_o(grant_idx),
    .grant_prio_o(grant_prio), .grant_mask_o(clr_mask)
  );

  assign save_frame = '{nmi_busy: nmi_busy_q, ie: ie_q, isp: isp_q};

  nia_flag_stack #(.DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst(rst), .push_i(grant), .pop_i(reti_i),
    .din_i(save_frame), .dout_o(top_frame), .full_o(full), .empty_o(empty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q       <= 1'b0;
      isp_q      <= 1'b1;
      nmi_busy_q <= 1'b0;
      skip_q     <= 1'b0;
      ack_q      <= 1'b0;
      vec_q      <= '0;
    end else begin
      ack_q <= grant;
      if (grant) vec_q <= grant_idx;

      if (reti_i)          skip_q <= 1'b1;
      else if (boundary_i) skip_q <= 1'b0;

      if (reti_i) begin
        if (!empty) begin
          ie_q       <= top_frame.ie;
          isp_q      <= top_frame.isp;
          nmi_busy_q <= top_frame.nmi_busy;
        end
      end else if (grant) begin
        ie_q  <= 1'b0;
        isp_q <= grant_nmi ? 1'b0 : grant_prio;
        if (grant_nmi) nmi_busy_q <= 1'b1;
      end else if (di_i) begin
        ie_q <= 1'b0;
      end else if (ei_i) begin
        ie_q <= 1'b1;
      end
    end
  end

  assign ack_o      = ack_q;
  assign vec_o      = vec_q;
  assign ie_o       = ie_q;
  assign isp_o      = isp_q;
  assign nmi_busy_o = nmi_busy_q;
endmodule

// File: rtl/nia_checker.sv
module nia_checker #(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             boundary_i,
  input logic             reti_i,
  input logic [N_SRC-1:0] prio_i,
  input logic             ack_o,
  input logic [IDX_W-1:0] vec_o,
  input logic             ie_o,
  input logic             isp_o,
  input logic             nmi_busy_o
);
  localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(N_SRC);

  logic [N_SRC-1:0] prio_q;
  logic             prio_sel;

  always_ff @(posedge clk) begin
    if (rst) prio_q <= '0;
    else     prio_q <= prio_i;
  end

  always_comb begin
    prio_sel = 1'b0;
    for (int i = 0; i < N_SRC; i++)
      if (vec_o == IDX_W'(i)) prio_sel = prio_q[i];
  end

  AST_ACK_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> $past(boundary_i)); // R3
  AST_ACK_DROPS_IE: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> !ie_o); // R3
  AST_MASKABLE_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    (ack_o && vec_o != NMI_IDX) |-> $past(ie_o)); // R2
  AST_ISP_TAKES_PRIO: assert property (@(posedge clk) disable iff (rst)
    (ack_o && vec_o != NMI_IDX) |-> (isp_o == prio_sel)); // R5
  AST_LOW_NEEDS_ISP: assert property (@(posedge clk) disable iff (rst)
    (ack_o && vec_o != NMI_IDX && prio_sel) |-> $past(isp_o)); // R5
  AST_RETURN_HOLDS_OFF: assert property (@(posedge clk) disable iff (rst)
    reti_i |=> !ack_o); // R8
  AST_NMI_SERVICE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    nmi_busy_o |=> !ack_o); // R9
  AST_NMI_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (ack_o && vec_o == NMI_IDX) |-> (nmi_busy_o && !isp_o)); // R9
endmodule

bind nest_irq_arbiter nia_checker #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst(rst), .boundary_i(boundary_i), .reti_i(reti_i),
  .prio_i(prio_i), .ack_o(ack_o), .vec_o(vec_o), .ie_o(ie_o),
  .isp_o(isp_o), .nmi_busy_o(nmi_busy_o)
);

// File: tb/nest_irq_arbiter_tb.sv
module nest_irq_arbiter_tb;
  localparam int N = 8;
  localparam int IW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] req_i = '0, prio_i = '1;
  logic nmi_i = 1'b0, boundary_i = 1'b0, reti_i = 1'b0, ei_i = 1'b0, di_i = 1'b0;
  logic ack_o, ie_o, isp_o, nmi_busy_o;
  logic [IW-1:0] vec_o;

  always #4 clk = ~clk;

  nest_irq_arbiter #(.N_SRC(N)) u_dut (
    .clk(clk), .rst(rst), .req_i(req_i), .nmi_i(nmi_i), .prio_i(prio_i),
    .boundary_i(boundary_i), .reti_i(reti_i), .ei_i(ei_i), .di_i(di_i),
    .ack_o(ack_o), .vec_o(vec_o), .ie_o(ie_o), .isp_o(isp_o),
    .nmi_busy_o(nmi_busy_o)
  );

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;

  // Behavioural reference model
  int m_ie, m_isp, m_nb, m_ack, m_vec, m_skip, m_npend;
  logic [N-1:0] m_pend;
  int stk[$];

  always @(posedge clk) begin
    int g;
    if (rst) begin
      m_ie = 0; m_isp = 1; m_nb = 0; m_ack = 0; m_vec = 0; m_skip = 0;
      m_npend = 0; m_pend = '0; stk.delete();
    end else begin
      g = -1;
      if (boundary_i && !reti_i && !m_skip && stk.size() < N + 1) begin
        if (m_npend && !m_nb) g = N;
        else if (!m_nb && m_ie) begin
          for (int i = N - 1; i >= 0; i--) if (m_pend[i] && !prio_i[i]) g = i;
          if (g < 0 && m_isp)
            for (int i = N - 1; i >= 0; i--) if (m_pend[i] && prio_i[i]) g = i;
        end
      end
      m_ack = (g >= 0);
      if (g >= 0) m_vec = g;
      if (reti_i) begin
        if (stk.size() > 0) begin
          int f;
          f = stk.pop_back();
          m_nb = (f >> 2) & 1; m_ie = (f >> 1) & 1; m_isp = f & 1;
        end
      end else if (g >= 0) begin
        stk.push_back(m_nb * 4 + m_ie * 2 + m_isp);
        m_ie = 0;
        m_isp = (g == N) ? 0 : int'(prio_i[g]);
        if (g == N) m_nb = 1;
      end else if (di_i) m_ie = 0;
      else if (ei_i) m_ie = 1;
      if (reti_i) m_skip = 1; else if (boundary_i) m_skip = 0;
      if (g >= 0 && g < N) m_pend[g] = 1'b0;
      if (g == N) m_npend = 0;
      m_pend = m_pend | req_i;
      if (nmi_i) m_npend = 1;
    end
  end

  task automatic chk(string r, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", r, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R3 ack", int'(ack_o), m_ack);
      chk("R4 vec", int'(vec_o), m_vec);
      chk("R2 ie", int'(ie_o), m_ie);
      chk("R5 isp", int'(isp_o), m_isp);
      chk("R9 nmi_busy", int'(nmi_busy_o), m_nb);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clr();
    req_i = '0; nmi_i = 0; boundary_i = 0; reti_i = 0; ei_i = 0; di_i = 0;
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1: reset state
    chk("R1 ie", int'(ie_o), 0);
    chk("R1 isp", int'(isp_o), 1);
    chk("R1 nmi_busy", int'(nmi_busy_o), 0);
    chk("R1 ack", int'(ack_o), 0);

    // R2: disabled, request stays pending
    req_i = 8'h08; cyc(); clr();
    boundary_i = 1; cyc(); clr();
    chk("R2 no ack while disabled", int'(ack_o), 0);
    ei_i = 1; cyc(); clr();
    chk("R2 enable set", int'(ie_o), 1);
    boundary_i = 1; cyc(); clr();
    chk("R3 ack", int'(ack_o), 1);
    chk("R3 vec", int'(vec_o), 3);
    chk("R3 ie cleared", int'(ie_o), 0);
    chk("R5 isp low", int'(isp_o), 1);
    cyc();
    chk("R3 single pulse", int'(ack_o), 0);

    // R4: high beats low regardless of index
    prio_i[6] = 0; req_i = 8'h44; cyc(); clr();
    ei_i = 1; cyc(); clr();
    boundary_i = 1; cyc(); clr();
    chk("R4 high wins", int'(vec_o), 6);
    chk("R5 isp high", int'(isp_o), 0);

    // R5: low blocked under high service, high nests
    ei_i = 1; cyc(); clr();
    boundary_i = 1; cyc(); clr();
    chk("R5 low blocked", int'(ack_o), 0);
    prio_i[4] = 0; req_i = 8'h10; cyc(); clr();
    boundary_i = 1; cyc(); clr();
    chk("R5 equal nests", int'(ack_o), 1);
    chk("R5 equal nests vec", int'(vec_o), 4);

    // R7: returns restore saved flags
    reti_i = 1; cyc(); clr();
    chk("R7 ie restored", int'(ie_o), 1);
    chk("R7 isp restored", int'(isp_o), 0);
    reti_i = 1; cyc(); clr();
    chk("R7 isp restored outer", int'(isp_o), 1);

    // R8 and R6: one instruction hold-off, then pending low source served
    boundary_i = 1; cyc(); clr();
    chk("R8 first boundary held", int'(ack_o), 0);
    boundary_i = 1; cyc(); clr();
    chk("R6 pending granted", int'(ack_o), 1);
    chk("R6 pending vec", int'(vec_o), 2);

    // R10: served source does not repeat
    ei_i = 1; cyc(); clr();
    boundary_i = 1; cyc(); clr();
    chk("R10 no repeat", int'(ack_o), 0);

    // R9: non-maskable ignores enable and blocks nesting
    di_i = 1; cyc(); clr();
    nmi_i = 1; cyc(); clr();
    boundary_i = 1; cyc(); clr();
    chk("R9 nmi ack", int'(ack_o), 1);
    chk("R9 nmi vec", int'(vec_o), N);
    chk("R9 busy", int'(nmi_busy_o), 1);
    ei_i = 1; cyc(); clr();
    prio_i[0] = 0; req_i = 8'h01; cyc(); clr();
    boundary_i = 1; cyc(); clr();
    chk("R9 no nesting", int'(ack_o), 0);
    reti_i = 1; cyc(); clr();
    chk("R7 busy restored", int'(nmi_busy_o), 0);
    chk("R7 ie restored after nmi", int'(ie_o), 0);
    ei_i = 1; cyc(); clr();
    boundary_i = 1; cyc(); clr();
    chk("R8 held after nmi return", int'(ack_o), 0);
    boundary_i = 1; cyc(); clr();
    chk("R6 source 0 served", int'(vec_o), 0);
    reti_i = 1; cyc(); clr();
    reti_i = 1; cyc(); clr();
    reti_i = 1; cyc(); clr();

    // Random traffic compared against the model every clock
    for (int k = 0; k < 4000; k++) begin
      boundary_i = ($urandom % 2) == 0;
      if (!boundary_i && ($urandom % 16) == 0) prio_i = N'($urandom);
      req_i = (($urandom % 6) == 0) ? N'(1 << ($urandom % N)) : '0;
      nmi_i = ($urandom % 60) == 0;
      reti_i = (stk.size() > 0) && (($urandom % 5) == 0);
      ei_i = ($urandom % 4) == 0;
      di_i = ($urandom % 12) == 0;
      cyc();
    end
    clr();
    cyc();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule